// File: doc/BRIEF.md
# Two-Level Write-Back Cache Controller

This block handles word reads and word writes from a processor. Requests pass through a small direct-mapped first-level cache and then a four-way set-associative second-level cache, both in front of a main memory. The two cache levels and the main memory are register arrays inside the block. Each block holds one word. Both cache levels use write-back: a write that hits sets a dirty flag, and the data moves up to the next level only when that line is evicted. Neither level allocates a line on a write miss. The write goes to the first level above that holds the address, or to main memory if no cache level holds it.

The processor starts a request by raising `req_i` while `wait_o` is low. `wait_o` then stays high for a fixed number of cycles, set by the level that completes the request: 1 cycle for a first-level hit, 4 for a second-level hit and 10 for main memory. On the cycle after `wait_o` falls, `rdata_o` holds the read data and `hit_o` shows which level served the request. Inside the second level, a 2-bit age per way picks the least recently used way to replace.

Top module: `cache_ctrl_2l`

## Requirements
- R1: After reset, `wait_o` is 0, `hit_o` is 2'b00 and `rdata_o` is 0. Every cache line is invalid. Main-memory word `a` holds `(3*a+1) mod 256`.
- R2: A request is taken only on a rising edge where `req_i` is 1 and `wait_o` is 0, and `wait_o` is 1 in the next cycle. A `req_i` raised while `wait_o` is high is ignored and does not change any array.
- R3: A read or write that hits in the first level keeps `wait_o` high for exactly 1 cycle and sets `hit_o` to 2'b01. A read returns the stored word.
- R4: A read that misses the first level and hits the second level keeps `wait_o` high for exactly 4 cycles, sets `hit_o` to 2'b10 and returns the word. It also fills the first-level line, so an immediate re-read is a first-level hit.
- R5: A read that misses both levels keeps `wait_o` high for exactly 10 cycles and sets `hit_o` to 2'b00. It installs the word in both levels.
- R6: A write that hits the first level changes only that line and marks it dirty. A following read of the address returns the new data as a first-level hit.
- R7: A write that misses the first level but hits the second level updates the second-level line and marks it dirty. It takes 4 cycles with `hit_o` 2'b10, and it does not allocate a first-level line.
- R8: A write that misses both levels updates main memory. It takes 10 cycles with `hit_o` 2'b00, and it allocates no line in either cache level.
- R9: When a dirty first-level line is replaced, its data is written back: into the second-level line if that level holds the address, otherwise into main memory.
- R10: When a second-level miss finds all four ways of the set valid, the way that was accessed least recently is replaced. Access means a fill or a hit. Ways that are invalid are used first, lowest index first.
- R11: When a dirty second-level line is replaced, its data is written to main memory before the way is reused.
- R12: While `wait_o` is high, `rdata_o` and `hit_o` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request strobe, sampled while `wait_o` is low |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 8 | Word address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid once `wait_o` has fallen |
| hit_o | output | 2 | Serving level: 01 first level, 10 second level, 00 memory |
| wait_o | output | 1 | High while a request is in progress |

## Verification
Two events can fall in the same cycle. In one memory access, the controller writes a dirty second-level victim to memory and fetches the requested word from memory. That victim's data may itself have arrived earlier from a first-level write-back. The bench sets up this case with a directed sequence in set 0: it writes a word into the first level, forces that line out into the second level, ages that way to the oldest position, and then forces a fifth block into the set. It judges the result by reading the original address back. That read must take the full memory latency and must return the written word. It also checks that the other ways stay resident in the order the ages predict.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_L1_LOOKUP,
    S_L2_LOOKUP,
    S_MEM_ACCESS,
    S_WRITEBACK,
    S_FILL
  } cc_state_e;
endpackage

// File: rtl/cc_way_match.sv
module cc_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             vld_i,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags_i,
  input  logic [TAG_W-1:0]            tag_i,
  output logic                        hit_o,
  output logic [WAY_W-1:0]            hit_way_o,
  output logic                        free_o,
  output logic [WAY_W-1:0]            free_way_o
);
  logic [WAYS-1:0] hit_vec;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec[g] = vld_i[g] && (tags_i[g] == tag_i);
  end

  always_comb begin
    hit_o      = |hit_vec;
    hit_way_o  = '0;
    free_o     = ~&vld_i;
    free_way_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_vec[w]) hit_way_o = WAY_W'(w);
    // descending scan: lowest free index wins
    for (int w = WAYS - 1; w >= 0; w--)
      if (!vld_i[w]) free_way_o = WAY_W'(w);
  end
endmodule

// File: rtl/cc_lru.sv
module cc_lru #(
  parameter int SETS = 4,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int AGE_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [SET_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [SET_W-1:0] set_i,
  output logic [WAY_W-1:0] victim_o
);
  logic [WAYS-1:0][AGE_W-1:0] age_q [SETS];
  logic [WAYS-1:0]            oldest;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[touch_set_i][w] <= '0;
        else if (age_q[touch_set_i][w] < age_q[touch_set_i][touch_way_i])
          age_q[touch_set_i][w] <= age_q[touch_set_i][w] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_old
    assign oldest[g] = (age_q[set_i][g] == AGE_W'(WAYS - 1));
  end

  always_comb begin
    victim_o = '0;
    for (int w = 0; w < WAYS; w++)
      if (oldest[w]) victim_o = WAY_W'(w);
  end

  a_r10_one_oldest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(oldest) == 1);
  a_r10_touch_youngest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> age_q[$past(touch_set_i)][$past(touch_way_i)] == '0);
endmodule

// File: rtl/cache_ctrl_2l.sv
module cache_ctrl_2l #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter int L1_IDX_W = 2,
  parameter int L2_SET_W = 2,
  parameter int L2_WAYS  = 4,
  parameter int L1_LAT   = 1,
  parameter int L2_LAT   = 4,
  parameter int MEM_LAT  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        hit_o,
  output logic              wait_o
);
  import cc_pkg::*;

  localparam int L1_LINES  = 1 << L1_IDX_W;
  localparam int L2_SETS   = 1 << L2_SET_W;
  localparam int MEM_WORDS = 1 << ADDR_W;
  localparam int WAY_W     = $clog2(L2_WAYS);
  localparam int T1_W      = ADDR_W - L1_IDX_W;
  localparam int T2_W      = ADDR_W - L2_SET_W;
  localparam int CNT_W     = $clog2(MEM_LAT + 2);
  localparam logic [1:0] SRC_L1 = 2'b01, SRC_L2 = 2'b10, SRC_MEM = 2'b00;

  cc_state_e state_q;
  logic [ADDR_W-1:0] a_q;
  logic              we_q;
  logic [DATA_W-1:0] wd_q, rdata_q;
  logic [1:0]        hit_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              l2hit_q;
  logic [WAY_W-1:0]  way_q;

  logic [L1_LINES-1:0] l1_vld_q, l1_dty_q;
  logic [T1_W-1:0]     l1_tag_q [L1_LINES];
  logic [DATA_W-1:0]   l1_dat_q [L1_LINES];
  logic [L2_WAYS-1:0]             l2_vld_q [L2_SETS];
  logic [L2_WAYS-1:0]             l2_dty_q [L2_SETS];
  logic [L2_WAYS-1:0][T2_W-1:0]   l2_tag_q [L2_SETS];
  logic [DATA_W-1:0]              l2_dat_q [L2_SETS][L2_WAYS];
  logic [DATA_W-1:0]              mem_q [MEM_WORDS];

  // request address split
  logic [L1_IDX_W-1:0] idx;
  logic [T1_W-1:0]     tag1;
  logic [L2_SET_W-1:0] set;
  logic [T2_W-1:0]     tag2;
  assign idx  = a_q[L1_IDX_W-1:0];
  assign tag1 = a_q[ADDR_W-1:L1_IDX_W];
  assign set  = a_q[L2_SET_W-1:0];
  assign tag2 = a_q[ADDR_W-1:L2_SET_W];

  // L1 victim address split
  logic [ADDR_W-1:0]   v_addr;
  logic [L2_SET_W-1:0] v_set;
  logic [T2_W-1:0]     v_tag2;
  assign v_addr = {l1_tag_q[idx], idx};
  assign v_set  = v_addr[L2_SET_W-1:0];
  assign v_tag2 = v_addr[ADDR_W-1:L2_SET_W];

  logic             l1_hit;
  logic             m_hit, m_free, v_hit, v_free;
  logic [WAY_W-1:0] m_way, m_free_way, v_way, v_free_way, lru_vic;
  logic             lat_ok, touch;
  logic [WAY_W-1:0] touch_way;

  assign l1_hit = l1_vld_q[idx] && (l1_tag_q[idx] == tag1);

  cc_way_match #(.WAYS(L2_WAYS), .TAG_W(T2_W)) u_req_match (
    .vld_i(l2_vld_q[set]), .tags_i(l2_tag_q[set]), .tag_i(tag2),
    .hit_o(m_hit), .hit_way_o(m_way), .free_o(m_free), .free_way_o(m_free_way));

  cc_way_match #(.WAYS(L2_WAYS), .TAG_W(T2_W)) u_vic_match (
    .vld_i(l2_vld_q[v_set]), .tags_i(l2_tag_q[v_set]), .tag_i(v_tag2),
    .hit_o(v_hit), .hit_way_o(v_way), .free_o(v_free), .free_way_o(v_free_way));

  always_comb begin
    unique case (state_q)
      S_L1_LOOKUP:  lat_ok = cnt_q >= CNT_W'(L1_LAT);
      S_L2_LOOKUP:  lat_ok = cnt_q >= CNT_W'(L2_LAT);
      S_MEM_ACCESS: lat_ok = cnt_q >= CNT_W'(MEM_LAT);
      S_FILL:       lat_ok = cnt_q >= (l2hit_q ? CNT_W'(L2_LAT) : CNT_W'(MEM_LAT));
      default:      lat_ok = 1'b0;
    endcase
    touch     = ((state_q == S_L2_LOOKUP) && we_q && m_hit && lat_ok) ||
                ((state_q == S_FILL) && lat_ok);
    touch_way = (state_q == S_FILL) ? way_q : m_way;
  end

  cc_lru #(.SETS(L2_SETS), .WAYS(L2_WAYS)) u_lru (
    .clk_i, .rst_ni, .touch_i(touch), .touch_set_i(set), .touch_way_i(touch_way),
    .set_i(set), .victim_o(lru_vic));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      a_q <= '0; we_q <= 1'b0; wd_q <= '0; rdata_q <= '0; hit_q <= SRC_MEM;
      cnt_q <= '0; l2hit_q <= 1'b0; way_q <= '0;
      l1_vld_q <= '0; l1_dty_q <= '0;
      for (int i = 0; i < L1_LINES; i++) begin
        l1_tag_q[i] <= '0; l1_dat_q[i] <= '0;
      end
      for (int s = 0; s < L2_SETS; s++) begin
        l2_vld_q[s] <= '0; l2_dty_q[s] <= '0; l2_tag_q[s] <= '0;
        for (int w = 0; w < L2_WAYS; w++) l2_dat_q[s][w] <= '0;
      end
      for (int i = 0; i < MEM_WORDS; i++) mem_q[i] <= DATA_W'(3 * i + 1);
    end else begin
      if (state_q != S_IDLE) cnt_q <= cnt_q + 1'b1;
      unique case (state_q)
        S_IDLE: if (req_i) begin
          a_q <= addr_i; we_q <= we_i; wd_q <= wdata_i;
          cnt_q <= CNT_W'(1);
          state_q <= S_L1_LOOKUP;
        end
        S_L1_LOOKUP: begin
          if (!l1_hit) state_q <= S_L2_LOOKUP;
          else if (lat_ok) begin
            if (we_q) begin
              l1_dat_q[idx] <= wd_q;
              l1_dty_q[idx] <= 1'b1;
            end else rdata_q <= l1_dat_q[idx];
            hit_q   <= SRC_L1;
            state_q <= S_IDLE;
          end
        end
        S_L2_LOOKUP: begin
          l2hit_q <= m_hit;
          way_q   <= m_hit ? m_way : (m_free ? m_free_way : lru_vic);
          if (!we_q) state_q <= S_WRITEBACK;
          else if (!m_hit) state_q <= S_MEM_ACCESS;
          else if (lat_ok) begin
            l2_dat_q[set][m_way] <= wd_q;
            l2_dty_q[set][m_way] <= 1'b1;
            hit_q   <= SRC_L2;
            state_q <= S_IDLE;
          end
        end
        S_WRITEBACK: begin
          if (l1_vld_q[idx] && l1_dty_q[idx]) begin
            if (v_hit) begin
              l2_dat_q[v_set][v_way] <= l1_dat_q[idx];
              l2_dty_q[v_set][v_way] <= 1'b1;
            end else mem_q[v_addr] <= l1_dat_q[idx];
          end
          state_q <= l2hit_q ? S_FILL : S_MEM_ACCESS;
        end
        S_MEM_ACCESS: begin
          if (we_q) begin
            if (lat_ok) begin
              mem_q[a_q] <= wd_q;
              hit_q   <= SRC_MEM;
              state_q <= S_IDLE;
            end
          end else begin
            // evict dirty victim and fetch the new word in one cycle
            if (l2_vld_q[set][way_q] && l2_dty_q[set][way_q])
              mem_q[{l2_tag_q[set][way_q], set}] <= l2_dat_q[set][way_q];
            l2_tag_q[set][way_q] <= tag2;
            l2_dat_q[set][way_q] <= mem_q[a_q];
            l2_vld_q[set][way_q] <= 1'b1;
            l2_dty_q[set][way_q] <= 1'b0;
            state_q <= S_FILL;
          end
        end
        S_FILL: if (lat_ok) begin
          l1_tag_q[idx] <= tag1;
          l1_dat_q[idx] <= l2_dat_q[set][way_q];
          l1_vld_q[idx] <= 1'b1;
          l1_dty_q[idx] <= 1'b0;
          rdata_q <= l2_dat_q[set][way_q];
          hit_q   <= l2hit_q ? SRC_L2 : SRC_MEM;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign wait_o  = (state_q != S_IDLE);
  assign rdata_o = rdata_q;
  assign hit_o   = hit_q;

  a_r2_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !wait_o) |=> wait_o);
  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |-> ($stable(rdata_o) && $stable(hit_o)));
  a_r5_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |-> (cnt_q <= CNT_W'(MEM_LAT)));
  a_r7_no_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_q && (state_q inside {S_L2_LOOKUP, S_MEM_ACCESS})) |=> $stable(l1_vld_q));
endmodule

// File: tb/cache_ctrl_2l_tb.sv
`timescale 1ns/1ps
module cache_ctrl_2l_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic [1:0] hit;
  logic       wt;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cache_ctrl_2l u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .hit_o(hit), .wait_o(wt));

  function automatic logic [7:0] init_val(input int a);
    return 8'((3 * a + 1) % 256);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", rq, what, act, exp);
    end
  endtask

  // one request; checks wait length, serving level, read data and hold
  task automatic access(input logic w, input logic [7:0] a, input logic [7:0] d,
                        input int exp_wait, input logic [1:0] exp_hit,
                        input logic [7:0] exp_rd, input string rq);
    int n = 0;
    bit steady = 1;
    logic [7:0] r0;
    logic [1:0] h0;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    r0 = rdata; h0 = hit;
    while (wt && n < 200) begin
      n++;
      if (rdata !== r0 || hit !== h0) steady = 0;
      @(negedge clk);
    end
    chk(n == exp_wait, rq, $sformatf("wait cycles addr=%0h", a), n, exp_wait);
    chk(hit == exp_hit, rq, $sformatf("hit_o addr=%0h", a), hit, exp_hit);
    if (!w) chk(rdata == exp_rd, rq, $sformatf("rdata addr=%0h", a), rdata, exp_rd);
    chk(steady, "R12", "outputs held while waiting", steady, 1);
  endtask

  task automatic t_reset;
    chk(wt == 1'b0, "R1", "wait after reset", wt, 0);
    chk(hit == 2'b00, "R1", "hit after reset", hit, 0);
    chk(rdata == 8'h00, "R1", "rdata after reset", rdata, 0);
  endtask

  task automatic t_mem_then_l1;
    access(0, 8'h00, 0, 10, 2'b00, init_val(0), "R5");
    access(0, 8'h00, 0, 1, 2'b01, init_val(0), "R3");
  endtask

  task automatic t_busy_ignored;
    int n = 0;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 8'h05;
    @(negedge clk);
    chk(wt == 1'b1, "R2", "wait rises after accept", wt, 1);
    we = 1'b1; wdata = 8'hEE;  // held high through the busy window
    while (wt && n < 200) begin
      n++;
      @(negedge clk);
    end
    req = 1'b0; we = 1'b0;
    chk(n == 10, "R2", "busy window length", n, 10);
    chk(rdata == init_val(5), "R2", "read data during ignored strobe", rdata, init_val(5));
    access(0, 8'h05, 0, 1, 2'b01, init_val(5), "R2");
  endtask

  task automatic t_l1_write;
    access(1, 8'h00, 8'h5A, 1, 2'b01, 0, "R6");
    access(0, 8'h00, 0, 1, 2'b01, 8'h5A, "R6");
  endtask

  task automatic t_l1_writeback;
    access(0, 8'h04, 0, 10, 2'b00, init_val(4), "R9");
    access(0, 8'h00, 0, 4, 2'b10, 8'h5A, "R9");
    access(0, 8'h00, 0, 1, 2'b01, 8'h5A, "R4");
  endtask

  task automatic t_write_l2;
    access(1, 8'h04, 8'h77, 4, 2'b10, 0, "R7");
    access(0, 8'h04, 0, 4, 2'b10, 8'h77, "R7");
  endtask

  task automatic t_write_mem;
    access(1, 8'h21, 8'h3C, 10, 2'b00, 0, "R8");
    access(0, 8'h21, 0, 10, 2'b00, 8'h3C, "R8");
  endtask

  task automatic t_lru;
    access(0, 8'h08, 0, 10, 2'b00, init_val(8), "R10");
    access(0, 8'h0C, 0, 10, 2'b00, init_val(12), "R10");
    access(0, 8'h10, 0, 10, 2'b00, init_val(16), "R10");
    access(0, 8'h04, 0, 4, 2'b10, 8'h77, "R10");
    access(0, 8'h00, 0, 10, 2'b00, 8'h5A, "R11");
    access(0, 8'h0C, 0, 4, 2'b10, init_val(12), "R10");
    access(0, 8'h08, 0, 10, 2'b00, init_val(8), "R10");
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mem_then_l1();
    t_busy_ignored();
    t_l1_write();
    t_l1_writeback();
    t_write_l2();
    t_write_mem();
    t_lru();
    finish_run();
  end
endmodule